// File: doc/BRIEF.md
# Clock Mode Control Register

This block is the byte-wide control register that sits in front of an on-chip clock generator. Software writes it through a plain write strobe with a data byte, and reads it back through an always-valid read byte. It holds four fields. The first is a frequency-range bit. The second picks the external reference type (crystal or driven clock). The third is a 2-bit clock mode field. The fourth is an oscillator-stop enable. One reserved bit is stored with no function, and the two remaining bits read as zero.

The block applies protection rules that last until reset. The range and reference-type bits accept only the first register write after reset. If that first write leaves the mode field's upper bit at 0, both external-reference modes stay out of reach until the next reset. A small state machine tracks each accepted mode request, with three states. ST_IDLE means nothing is pending. ST_WAIT_REF means the request is bypassed-external and is waiting for the external reference to become stable. ST_WAIT_DONE means the block is waiting for the clock switch to report completion.

The transitions are as follows. An accepted write goes from ST_IDLE to ST_WAIT_REF for mode 10, and to ST_WAIT_DONE for any other mode. ST_WAIT_REF moves to ST_WAIT_DONE once `ext_ref_ready` is high. ST_WAIT_DONE returns to ST_IDLE on a `switch_done` pulse, and that return copies the requested mode into the selected mode. The block also outputs the loop prescale factor that goes with the range and the selected mode.

Top module: `clk_mode_ctl`

## Requirements
- R1: After reset, `rd_data` is 0x44, `sel_mode` is 00, `change_pending` is 0 and `prescale` is 1. Register bit layout: bit 6 range, bit 5 reference type, bits 4:3 mode, bit 2 oscillator-stop enable, bit 0 reserved, bits 7 and 1 zero.
- R2: The range bit (bit 6) takes the value of the first write after reset. Later writes leave it unchanged.
- R3: The reference-type bit (bit 5) takes the value of the first write after reset. Later writes leave it unchanged.
- R4: The oscillator-stop enable (bit 2) and the reserved bit (bit 0) follow every write. Bits 7 and 1 always read 0.
- R5: `prescale` is 64 when range is 0 and the selected mode is 10 or 11. In every other case it is 1.
- R6: Mode encoding is 00 self-clocked, 01 loop engaged on internal reference, 10 loop bypassed on external reference, 11 loop engaged on external reference. If the first write after reset has bit 4 at 0, later writes of mode 10 or 11 are ignored until reset.
- R7: An accepted mode write shows in the read-back mode field and raises `change_pending` one cycle later. `sel_mode` keeps its old value while the change is pending.
- R8: While `change_pending` is 1, the mode field of a write is ignored. The other writable, unlocked bits of that write still update.
- R9: For requested mode 10, `switch_done` pulses have no effect until `ext_ref_ready` has been seen high.
- R10: A `switch_done` pulse in ST_WAIT_DONE copies the requested mode into `sel_mode` and clears `change_pending` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read-back |
| ext_ref_ready | input | 1 | External reference is stable |
| switch_done | input | 1 | Clock switch has completed |
| sel_mode | output | 2 | Mode currently in effect |
| change_pending | output | 1 | A mode request is not yet complete |
| prescale | output | 7 | Loop prescale factor (1 or 64) |

## Verification
A wrong lock flag shows up on the next read as a mode field that moved when it should have held, or that held when it should have moved. A wrong state in the request machine shows up the cycle after a `switch_done` pulse, either as a `sel_mode` that changed too early or as a `change_pending` that failed to clear. A broken write-once bit shows in `rd_data` one cycle after the second write, and it also shows in `prescale` as soon as an external mode is selected.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
    typedef enum logic [1:0] {
        MODE_SELF     = 2'b00,
        MODE_FLL_INT  = 2'b01,
        MODE_BYP_EXT  = 2'b10,
        MODE_FLL_EXT  = 2'b11
    } clk_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_WAIT_REF  = 2'b01,
        ST_WAIT_DONE = 2'b10
    } req_state_t;
endpackage

// File: rtl/clk_once_bit.sv
module clk_once_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic d,
    output logic q
);
    logic taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= RST_VAL;
            taken <= 1'b0;
        end else if (wr_en && !taken) begin
            q     <= d;
            taken <= 1'b1;
        end
    end

    // R2 / R3: once taken, the bit never moves again
    p_once_stable_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> $stable(q));
endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
    import clk_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       ext_ref_ready,
    input  logic       switch_done,
    output logic [1:0] req_mode,
    output logic [1:0] sel_mode,
    output logic       pending
);
    req_state_t state_q, state_d;
    logic       first_seen;
    logic       ext_blocked;
    logic       accept;

    assign accept  = wr_en && (state_q == ST_IDLE) && !(ext_blocked && wr_mode[1]);
    assign pending = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = (wr_mode == MODE_BYP_EXT) ? ST_WAIT_REF : ST_WAIT_DONE;
            end
            ST_WAIT_REF: begin
                if (ext_ref_ready)
                    state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (switch_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_mode    <= MODE_SELF;
            sel_mode    <= MODE_SELF;
            first_seen  <= 1'b0;
            ext_blocked <= 1'b0;
        end else begin
            if (wr_en && !first_seen) begin
                first_seen  <= 1'b1;
                ext_blocked <= !wr_mode[1];
            end
            if (accept)
                req_mode <= wr_mode;
            if (state_q == ST_WAIT_DONE && switch_done)
                sel_mode <= req_mode;
        end
    end

    p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_blocked |=> !req_mode[1]);

    p_ignore_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_en) |=> $stable(req_mode));

    p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REF && !ext_ref_ready) |=> (state_q == ST_WAIT_REF));

    p_sel_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(state_q == ST_WAIT_DONE && switch_done)) |=> $stable(sel_mode));

    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DONE && switch_done) |=> (!pending && sel_mode == $past(req_mode)));
endmodule

// File: rtl/clk_mode_ctl.sv
module clk_mode_ctl
    import clk_mode_pkg::*;
#(
    parameter int PRESCALE_LO = 64,
    parameter int PRESCALE_HI = 1,
    localparam int PW = $clog2(PRESCALE_LO + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          ext_ref_ready,
    input  logic          switch_done,
    output logic [1:0]    sel_mode,
    output logic          change_pending,
    output logic [PW-1:0] prescale
);
    localparam int N_ONCE = 2;
    localparam logic [N_ONCE-1:0] ONCE_RST = 2'b10;

    logic [N_ONCE-1:0] once_q;
    logic [1:0]        req_mode;
    logic              osc_stop_q;
    logic              rsv_q;

    for (genvar i = 0; i < N_ONCE; i++) begin : g_once
        localparam int POS = (i == 1) ? 6 : 5;
        clk_once_bit #(.RST_VAL(ONCE_RST[i])) u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_en),
            .d    (wr_data[POS]),
            .q    (once_q[i])
        );
    end

    clk_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_mode      (wr_data[4:3]),
        .ext_ref_ready(ext_ref_ready),
        .switch_done  (switch_done),
        .req_mode     (req_mode),
        .sel_mode     (sel_mode),
        .pending      (change_pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_stop_q <= 1'b1;
            rsv_q      <= 1'b0;
        end else if (wr_en) begin
            osc_stop_q <= wr_data[2];
            rsv_q      <= wr_data[0];
        end
    end

    assign rd_data  = {1'b0, once_q[1], once_q[0], req_mode, osc_stop_q, 1'b0, rsv_q};
    assign prescale = (sel_mode[1] && !once_q[1]) ? PW'(PRESCALE_LO) : PW'(PRESCALE_HI);

    p_prescale_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_mode[1] && $stable(sel_mode)) |-> (prescale == PW'(PRESCALE_HI)));
endmodule

// File: tb/clk_mode_ctl_test.sv
module clk_mode_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_ref_ready = 1'b0;
    logic       switch_done = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] sel_mode;
    logic       change_pending;
    logic [6:0] prescale;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_ref_ready(ext_ref_ready),
        .switch_done(switch_done), .sel_mode(sel_mode),
        .change_pending(change_pending), .prescale(prescale)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        switch_done = 1'b0;
        ext_ref_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        switch_done = 1'b1;
        @(negedge clk);
        switch_done = 1'b0;
    endtask

    function automatic logic [7:0] mk(input int rng, input int ref_t, input int mode,
                                      input int osc, input int rsv);
        return {1'b0, 1'(rng), 1'(ref_t), 2'(mode), 1'(osc), 1'b0, 1'(rsv)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 4; m++) begin
                int ref_t = (m + r) % 2;
                int exp_sel;
                do_reset();
                // R1: reset state
                chk("R1 rd", rd_data, 8'h44);
                chk("R1 sel", sel_mode, 0);
                chk("R1 pend", change_pending, 0);
                chk("R1 pre", prescale, 1);

                // first write: range, ref type, mode m, osc=1, rsv=1
                wr(mk(r, ref_t, m, 1, 1));
                chk("R2 range", rd_data[6], r);
                chk("R3 ref", rd_data[5], ref_t);
                chk("R7 mode rd", rd_data[4:3], m);
                chk("R7 pend", change_pending, 1);
                chk("R7 sel held", sel_mode, 0);
                chk("R4 zeros", {rd_data[7], rd_data[1]}, 0);

                // R8: write while pending, mode ignored, osc/rsv updated
                wr(mk(1 - r, 1 - ref_t, (m + 1) % 4, 0, 0));
                chk("R8 mode", rd_data[4:3], m);
                chk("R8 osc", rd_data[2], 0);
                chk("R4 rsv", rd_data[0], 0);
                chk("R2 once", rd_data[6], r);
                chk("R3 once", rd_data[5], ref_t);

                if (m == 2) begin
                    // R9: done ignored until reference ready
                    pulse_done();
                    chk("R9 pend", change_pending, 1);
                    chk("R9 sel", sel_mode, 0);
                    ext_ref_ready = 1'b1;
                    @(negedge clk);
                    ext_ref_ready = 1'b0;
                    chk("R9 still pend", change_pending, 1);
                end
                pulse_done();
                chk("R10 sel", sel_mode, m);
                chk("R10 pend", change_pending, 0);
                exp_sel = m;
                chk("R5 pre", prescale, ((exp_sel >= 2) && (r == 0)) ? 64 : 1);

                // R6: try mode 3 now that nothing is pending
                wr(mk(r, ref_t, 3, 1, 0));
                if (m < 2) begin
                    chk("R6 blocked", rd_data[4:3], m);
                    chk("R6 no pend", change_pending, 0);
                    chk("R4 osc", rd_data[2], 1);
                end else begin
                    chk("R6 open", rd_data[4:3], 3);
                    chk("R7 pend2", change_pending, 1);
                    pulse_done();
                    chk("R10 sel3", sel_mode, 3);
                    chk("R5 pre3", prescale, (r == 0) ? 64 : 1);
                end
            end
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule